// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block performs entry into the software trap exception of a 32-bit processor core. When the request input is raised while the sequencer is idle, it decodes the two instruction halfwords. If they form the trap instruction, it captures the 5-bit vector, the address of the trap instruction and the current status word. It then builds the exception context in three clock cycles.

The context has five parts. The saved return address is the trap address plus 4. The saved status is a copy of the incoming status word. The cause code is derived from the vector. The new status word has the exception-pending and interrupt-disable bits forced on. The redirected program counter is one of two fixed handler entry points, chosen by the upper or lower half of the vector range. All five results appear together in the cycle in which `done_o` pulses, and they hold until the next trap completes. The core's register file and fetch unit take the results from that pulse.

Top module: `trap_entry_seq`

## Requirements
- R1: A request is accepted only if bits 15..5 of `hw0_i` equal 11'b00000111111 and `hw1_i` equals 16'h0100. A request with any other encoding starts nothing: `busy_o` stays low and every result output keeps its value.
- R2: `epc_o` equals the `pc_i` value sampled at acceptance plus 4. `epsw_o` equals the `psw_i` value sampled at acceptance. Inputs that change after acceptance have no effect.
- R3: `npsw_o` equals the sampled status word with bit 6 (exception pending) and bit 5 (interrupt disable) set to 1. All other bits are unchanged.
- R4: `cause_o` equals 16'h0040 plus the vector, where the vector is `hw0_i[4:0]` sampled at acceptance.
- R5: `npc_o` is 32'h0000_0040 for vectors 0 to 15 and 32'h0000_0050 for vectors 16 to 31.
- R6: `busy_o` is high for the two cycles after the accepting clock edge. In the third cycle `done_o` is high for exactly one cycle with `busy_o` low, and all result outputs change together in that cycle only.
- R7: A request presented while `busy_o` or `done_o` is high is ignored. It does not restart the sequence and does not alter the results of the trap in progress.
- R8: After reset, `busy_o` and `done_o` are low and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Trap request, sampled while idle |
| hw0_i | input | 16 | First instruction halfword (opcode and vector) |
| hw1_i | input | 16 | Second instruction halfword (sub-opcode) |
| pc_i | input | 32 | Address of the trap instruction |
| psw_i | input | 32 | Current status word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when results are committed |
| epc_o | output | 32 | Saved return address |
| epsw_o | output | 32 | Saved status word |
| cause_o | output | 16 | Exception cause code |
| npsw_o | output | 32 | Updated status word |
| npc_o | output | 32 | Handler entry address |

## Verification
The hardest case to reach is a second, correctly encoded request that arrives while the first trap is still being built. This includes a request in the done cycle itself, where an early return to idle would accept it. The stimulus holds the request high with a different vector and different address and status values from the cycle after acceptance through the done cycle. It then checks that the committed results belong to the first trap and that `busy_o` stays low in the following cycle. Separately, every single-bit corruption of both halfwords is presented to show that near-miss encodings never start the sequencer.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_CALC = 2'd2,
    ST_DONE = 2'd3
  } trap_state_e;

endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/trap_decode.sv
module trap_decode #(
  parameter int          HW_W      = 16,
  parameter int          VEC_W     = 5,
  parameter logic [15:0] FIRST_PAT = 16'h07E0,
  parameter logic [15:0] SECOND_PAT = 16'h0100
) (
  input  logic [HW_W-1:0]  hw0,
  input  logic [HW_W-1:0]  hw1,
  output logic             is_trap,
  output logic [VEC_W-1:0] vec
);

  localparam int OPC_W = HW_W - VEC_W;

  logic [OPC_W-1:0] opc_field;
  logic             first_hit;
  logic             second_hit;

  always_comb begin
    opc_field  = hw0[HW_W-1:VEC_W];
    first_hit  = (opc_field == FIRST_PAT[HW_W-1:VEC_W]);
    second_hit = (hw1 == SECOND_PAT[HW_W-1:0]);
    is_trap    = first_hit && second_hit;
    vec        = hw0[VEC_W-1:0];
  end

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cap_en,
  output logic calc_en,
  output logic commit_en,
  output logic busy,
  output logic done
);

  trap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_CAP;
      ST_CAP:  state_d = ST_CALC;
      ST_CALC: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    cap_en    = (state_q == ST_IDLE) && start;
    calc_en   = (state_q == ST_CAP);
    commit_en = (state_q == ST_CALC);
    busy      = (state_q == ST_CAP) || (state_q == ST_CALC);
    done      = (state_q == ST_DONE);
  end

  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);  // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));  // R6
  AST_NO_START_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |=> !$rose(busy));  // R7

endmodule

// File: rtl/trap_ctx_calc.sv
module trap_ctx_calc #(
  parameter int              XLEN       = 32,
  parameter int              VEC_W      = 5,
  parameter int              CODE_W     = 16,
  parameter int              EP_BIT     = 6,
  parameter int              ID_BIT     = 5,
  parameter logic [XLEN-1:0] HANDLER_LO = 32'h0000_0040,
  parameter logic [XLEN-1:0] HANDLER_HI = 32'h0000_0050,
  parameter logic [CODE_W-1:0] CODE_BASE = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              calc_en,
  input  logic              commit_en,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   psw_i,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   epsw_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [XLEN-1:0]   npsw_o,
  output logic [XLEN-1:0]   npc_o
);

  localparam logic [XLEN-1:0] RET_OFS  = XLEN'(4);
  localparam logic [XLEN-1:0] SET_MASK = (XLEN'(1) << EP_BIT) | (XLEN'(1) << ID_BIT);

  // stage 1: capture
  logic [VEC_W-1:0]  vec_q;
  logic [XLEN-1:0]   pc_q, psw_q;
  // stage 2: computed context
  logic [XLEN-1:0]   epc_s, epsw_s, npsw_s, npc_s;
  logic [CODE_W-1:0] cause_s;
  logic [XLEN-1:0]   epc_c, npsw_c, npc_c;
  logic [CODE_W-1:0] cause_c;
  // stage 3: committed outputs
  logic [XLEN-1:0]   epc_q, epsw_q, npsw_q, npc_q;
  logic [CODE_W-1:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      pc_q  <= '0;
      psw_q <= '0;
    end else if (cap_en) begin
      vec_q <= vec_i;
      pc_q  <= pc_i;
      psw_q <= psw_i;
    end
  end

  always_comb begin
    epc_c   = pc_q + RET_OFS;
    npsw_c  = psw_q | SET_MASK;
    cause_c = CODE_W'(vec_q) + CODE_BASE;
    npc_c   = vec_q[VEC_W-1] ? HANDLER_HI : HANDLER_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_s   <= '0;
      epsw_s  <= '0;
      npsw_s  <= '0;
      npc_s   <= '0;
      cause_s <= '0;
    end else if (calc_en) begin
      epc_s   <= epc_c;
      epsw_s  <= psw_q;
      npsw_s  <= npsw_c;
      npc_s   <= npc_c;
      cause_s <= cause_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      epsw_q  <= '0;
      npsw_q  <= '0;
      npc_q   <= '0;
      cause_q <= '0;
    end else if (commit_en) begin
      epc_q   <= epc_s;
      epsw_q  <= epsw_s;
      npsw_q  <= npsw_s;
      npc_q   <= npc_s;
      cause_q <= cause_s;
    end
  end

  assign epc_o   = epc_q;
  assign epsw_o  = epsw_q;
  assign cause_o = cause_q;
  assign npsw_o  = npsw_q;
  assign npc_o   = npc_q;

  AST_EPC_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (epc_o == $past(pc_q) + RET_OFS));  // R2
  AST_PSW_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (npsw_o[EP_BIT] && npsw_o[ID_BIT]));  // R3
  AST_CAUSE_FROM_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (cause_o == CODE_W'($past(vec_q)) + CODE_BASE));  // R4
  AST_HANDLER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (npc_o == HANDLER_LO || npc_o == HANDLER_HI));  // R5
  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> ($stable(epc_o) && $stable(npc_o) && $stable(cause_o)));  // R6

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int                XLEN       = 32,
  parameter int                HW_W       = 16,
  parameter int                VEC_W      = 5,
  parameter int                CODE_W     = 16,
  parameter int                EP_BIT     = 6,
  parameter int                ID_BIT     = 5,
  parameter logic [XLEN-1:0]   HANDLER_LO = 32'h0000_0040,
  parameter logic [XLEN-1:0]   HANDLER_HI = 32'h0000_0050,
  parameter logic [CODE_W-1:0] CODE_BASE  = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [HW_W-1:0]   hw0_i,
  input  logic [HW_W-1:0]   hw1_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   psw_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   epsw_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [XLEN-1:0]   npsw_o,
  output logic [XLEN-1:0]   npc_o
);

  logic             rst_sn;
  logic             is_trap;
  logic [VEC_W-1:0] vec;
  logic             start;
  logic             cap_en, calc_en, commit_en;

  trap_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  trap_decode #(.HW_W(HW_W), .VEC_W(VEC_W)) u_dec (
    .hw0     (hw0_i),
    .hw1     (hw1_i),
    .is_trap (is_trap),
    .vec     (vec)
  );

  assign start = req_i && is_trap;

  trap_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .start     (start),
    .cap_en    (cap_en),
    .calc_en   (calc_en),
    .commit_en (commit_en),
    .busy      (busy_o),
    .done      (done_o)
  );

  trap_ctx_calc #(
    .XLEN(XLEN), .VEC_W(VEC_W), .CODE_W(CODE_W), .EP_BIT(EP_BIT), .ID_BIT(ID_BIT),
    .HANDLER_LO(HANDLER_LO), .HANDLER_HI(HANDLER_HI), .CODE_BASE(CODE_BASE)
  ) u_ctx (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cap_en    (cap_en),
    .calc_en   (calc_en),
    .commit_en (commit_en),
    .vec_i     (vec),
    .pc_i      (pc_i),
    .psw_i     (psw_i),
    .epc_o     (epc_o),
    .epsw_o    (epsw_o),
    .cause_o   (cause_o),
    .npsw_o    (npsw_o),
    .npc_o     (npc_o)
  );

  AST_IDLE_BAD_ENCODING: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy_o && !done_o && req_i && !is_trap) |=> !busy_o);  // R1
  AST_COMMIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    !done_o |-> ($stable(epsw_o) && $stable(npsw_o)));  // R6

endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [15:0] hw0_i, hw1_i;
  logic [31:0] pc_i, psw_i;
  logic        busy_o, done_o;
  logic [31:0] epc_o, epsw_o, npsw_o, npc_o;
  logic [15:0] cause_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] x_epc, x_epsw, x_npsw, x_npc;
  logic [15:0] x_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .hw0_i(hw0_i), .hw1_i(hw1_i),
    .pc_i(pc_i), .psw_i(psw_i), .busy_o(busy_o), .done_o(done_o),
    .epc_o(epc_o), .epsw_o(epsw_o), .cause_o(cause_o), .npsw_o(npsw_o), .npc_o(npc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_expect(input logic [4:0] v, input logic [31:0] pc, input logic [31:0] psw);
    x_epc   = pc + 32'd4;
    x_epsw  = psw;
    x_npsw  = psw | 32'h0000_0060;
    x_cause = 16'h0040 + {11'd0, v};
    x_npc   = (v < 5'd16) ? 32'h0000_0040 : 32'h0000_0050;
  endtask

  task automatic chk_results(input string tag);
    chk({tag, " R2 epc"},   epc_o,   x_epc);
    chk({tag, " R2 epsw"},  epsw_o,  x_epsw);
    chk({tag, " R3 npsw"},  npsw_o,  x_npsw);
    chk({tag, " R4 cause"}, {16'd0, cause_o}, {16'd0, x_cause});
    chk({tag, " R5 npc"},   npc_o,   x_npc);
  endtask

  // full trap: request in one cycle, then check timing and results
  task automatic run_trap(input logic [4:0] v, input logic [31:0] pc, input logic [31:0] psw);
    @(negedge clk);
    hw0_i = {11'b00000111111, v};
    hw1_i = 16'h0100;
    pc_i  = pc;
    psw_i = psw;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    hw0_i = 16'hFFFF; pc_i = ~pc; psw_i = ~psw;   // later input changes must not matter (R2)
    chk("R6 busy c1", {31'd0, busy_o}, 32'd1);
    chk("R6 done c1", {31'd0, done_o}, 32'd0);
    @(negedge clk);
    chk("R6 busy c2", {31'd0, busy_o}, 32'd1);
    chk("R6 outputs held c2 R6", epc_o, x_epc);
    @(negedge clk);
    chk("R6 done c3", {31'd0, done_o}, 32'd1);
    chk("R6 busy c3", {31'd0, busy_o}, 32'd0);
    set_expect(v, pc, psw);
    chk_results("run");
    @(negedge clk);
    chk("R6 done clears", {31'd0, done_o}, 32'd0);
    chk("R6 idle after", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic bad_req(input logic [15:0] h0, input logic [15:0] h1);
    @(negedge clk);
    hw0_i = h0; hw1_i = h1; pc_i = 32'hDEAD_0000; psw_i = 32'h0BAD_0BAD; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk("R1 no busy on bad encoding", {31'd0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R1 no done on bad encoding", {31'd0, done_o}, 32'd0);
    chk_results("R1 unchanged");
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; hw0_i = '0; hw1_i = '0; pc_i = '0; psw_i = '0;
    x_epc = '0; x_epsw = '0; x_npsw = '0; x_npc = '0; x_cause = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 busy", {31'd0, busy_o}, 32'd0);
    chk("R8 done", {31'd0, done_o}, 32'd0);
    chk_results("R8 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 busy after release", {31'd0, busy_o}, 32'd0);
    chk_results("R8 after release");

    // R2..R6: every vector, three context patterns
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 32; v++) begin
        logic [31:0] pc, psw;
        pc  = (p == 0) ? 32'h0000_1000 + 32'(v * 2)
            : (p == 1) ? 32'hFFFF_FFFE - 32'(v) : 32'h8000_0000 ^ 32'(v << 8);
        psw = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF : 32'hA5A5_A59F ^ 32'(v);
        run_trap(5'(v), pc, psw);
      end
    end

    // R1: every single-bit corruption of both halfwords
    for (int b = 5; b < 16; b++) bad_req(16'h07E0 ^ (16'h1 << b), 16'h0100);
    for (int b = 0; b < 16; b++) bad_req(16'h07F3, 16'h0100 ^ (16'h1 << b));

    // R7: valid requests held through busy and done are ignored
    @(negedge clk);
    hw0_i = {11'b00000111111, 5'd3}; hw1_i = 16'h0100;
    pc_i = 32'h0000_2000; psw_i = 32'h0000_0001; req_i = 1'b1;
    @(negedge clk);
    hw0_i = {11'b00000111111, 5'd29}; pc_i = 32'h0000_9000; psw_i = 32'h0000_0F00;
    chk("R7 busy first", {31'd0, busy_o}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R7 done", {31'd0, done_o}, 32'd1);
    set_expect(5'd3, 32'h0000_2000, 32'h0000_0001);
    chk_results("R7 first trap kept");
    @(negedge clk);
    req_i = 1'b0;
    chk("R7 request in done cycle ignored", {31'd0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R7 still idle", {31'd0, busy_o}, 32'd0);
    chk_results("R7 results unchanged");

    report();
  end

endmodule